// File: doc/BRIEF.md
# Double-Buffered Receive Signaling Buffer

This block moves per-channel signaling bytes from a line receiver to a microcontroller through two byte buffers of equal depth. The receiver writes a staging buffer one entry after another. An update event marks the end of each update period. At that event the whole staging buffer is copied in a single clock into a presentation buffer, and the copy completes before any write from the new period lands. The microcontroller reads the presentation buffer through one data port. The read position advances on each read and wraps, so reading exactly one period's quota every period keeps the reads aligned after a single pointer reset.

For test, the microcontroller can write the staging buffer through its own write strobe and can request a copy without an update event. Both hooks work only while the test enable is high. Each entry carries a configurable number of signaling bits, packed from the LSB, and the bits above that count read as zero. Four sticky flags report over- and under-runs of the per-period quota on each buffer. A status read clears them.

Top module: `sig_dbuf`

## Requirements
- R1: After reset both pointers select entry 1, every entry of both buffers is zero, and `flags` is 0.
- R2: When `upd_evt` is high, the presentation buffer takes a complete copy of the staging buffer as it stood before that edge, and the staging write pointer restarts. A write accepted in the same cycle goes to entry 1 of the new period, and the pointer then selects entry 2.
- R3: A receiver write (`rx_wr`) stores `rx_data` at the write pointer and advances the pointer only while `rx_oos` is low. While `rx_oos` is high the write changes no entry.
- R4: The presentation buffer changes only in a copy cycle.
- R5: `mc_rdata` shows the presentation entry at the read pointer. Each `mc_rd` advances the pointer, and the pointer wraps from the last entry to entry 1.
- R6: `ptr_rst` returns both pointers to entry 1. It takes priority over a read in the same cycle.
- R7: A test write (`mc_wr` with `test_en` high) stores `mc_wdata` at the write pointer and advances the pointer. It is ignored when `test_en` is low, and a receiver write wins when both arrive in the same cycle.
- R8: `force_upd` causes a copy only while `test_en` is high.
- R9: `nbits` from 1 to 7 keeps only the low `nbits` bits of `mc_rdata`. A value of 0 or 8 and above shows the full byte.
- R10: The quota depends on `period_sel`: 0 gives 48, 1 gives 24, 2 gives 16 and 3 gives 8. An access that arrives when the period already holds a quota's worth of accesses sets the over flag, `flags[0]` for staging writes and `flags[2]` for reads.
- R11: From the second copy onward, a copy that ends a period holding fewer accesses than the quota sets the under flag, `flags[1]` for writes and `flags[3]` for reads. An access in a copy cycle counts toward the new period.
- R12: The flags are sticky. `stat_rd` clears them at the next edge, but a flag that is set in that same cycle stays set.
- R13: A read in a copy cycle returns the old presentation contents. The next entry seen comes from the new copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| rx_wr | input | 1 | receiver write strobe |
| rx_data | input | 8 | receiver signaling byte |
| rx_oos | input | 1 | receiver framer out of sync |
| upd_evt | input | 1 | signaling update event |
| period_sel | input | 2 | update period setting, selects the quota |
| nbits | input | 4 | signaling bits per entry |
| test_en | input | 1 | test mode enable |
| mc_wr | input | 1 | test write strobe into the staging buffer |
| mc_wdata | input | 8 | test write data |
| force_upd | input | 1 | test copy request |
| ptr_rst | input | 1 | pointer reset request |
| mc_rd | input | 1 | read strobe, advances the read pointer |
| mc_rdata | output | 8 | masked presentation entry at the read pointer |
| stat_rd | input | 1 | status read, clears the flags |
| flags | output | 4 | {rd_under, rd_over, wr_under, wr_over} |

## Verification
`mc_rdata` is combinational from the registered read pointer and the presentation buffer. A copy, a read advance or a pointer reset therefore shows on it one edge after the strobe, and a change of `nbits` shows at once. The flags are registered and settle one edge after the access, copy or status read that affects them. The bench drives every strobe for one full cycle starting at a falling edge, and it samples at the next falling edge, after exactly one rising edge. A read's data is taken at the falling edge before the read strobe, which matches the pre-edge value the block presents.

// File: rtl/sig_dbuf_pkg.sv
package sig_dbuf_pkg;

    typedef enum logic [1:0] {
        PER_FULL  = 2'd0,
        PER_HALF  = 2'd1,
        PER_THIRD = 2'd2,
        PER_SIXTH = 2'd3
    } period_e;

    // entries expected per update period
    function automatic int unsigned quota_of(period_e p, int unsigned depth);
        case (p)
            PER_FULL:  return depth;
            PER_HALF:  return depth / 2;
            PER_THIRD: return depth / 3;
            default:   return depth / 6;
        endcase
    endfunction

endpackage

// File: rtl/sig_wrap_ptr.sv
module sig_wrap_ptr #(
    parameter int DEPTH = 48,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    typedef struct packed {
        logic [AW-1:0] ptr;
    } st_t;

    st_t st_d, st_q;
    logic [AW-1:0] base;

    always_comb begin
        st_d = st_q;
        base = clr ? '0 : st_q.ptr;
        if (inc) begin
            st_d.ptr = (base == AW'(DEPTH - 1)) ? '0 : base + 1'b1;
        end else begin
            st_d.ptr = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/sig_rate_mon.sv
module sig_rate_mon #(
    parameter int DEPTH = 48,
    localparam int CW = $clog2(DEPTH + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          access,
    input  logic          period_end,
    input  logic [CW-1:0] quota,
    input  logic          stat_clr,
    output logic          over,
    output logic          under
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
        logic          over;
        logic          under;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] base;
    logic          set_over;
    logic          set_under;

    always_comb begin
        st_d      = st_q;
        base      = period_end ? '0 : st_q.cnt;
        set_over  = access && (base >= quota);
        set_under = period_end && st_q.armed && (st_q.cnt < quota);
        if (access && base != CW'(DEPTH + 1)) begin
            st_d.cnt = base + 1'b1;
        end else begin
            st_d.cnt = base;
        end
        st_d.armed = st_q.armed | period_end;
        st_d.over  = set_over  | (st_q.over  & ~stat_clr);
        st_d.under = set_under | (st_q.under & ~stat_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign over  = st_q.over;
    assign under = st_q.under;
endmodule

// File: rtl/sig_dbuf.sv
module sig_dbuf
    import sig_dbuf_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int NBW  = $clog2(W + 1),
    localparam int CW   = $clog2(DEPTH + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_wr,
    input  logic [W-1:0]   rx_data,
    input  logic           rx_oos,
    input  logic           upd_evt,
    input  logic [1:0]     period_sel,
    input  logic [NBW-1:0] nbits,
    input  logic           test_en,
    input  logic           mc_wr,
    input  logic [W-1:0]   mc_wdata,
    input  logic           force_upd,
    input  logic           ptr_rst,
    input  logic           mc_rd,
    output logic [W-1:0]   mc_rdata,
    input  logic           stat_rd,
    output logic [3:0]     flags
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] in_mem;
        logic [DEPTH-1:0][W-1:0] out_mem;
    } st_t;

    st_t st_d, st_q;

    logic          rx_take;
    logic          tst_take;
    logic          wr_ok;
    logic          do_copy;
    logic [W-1:0]  wdata;
    logic [AW-1:0] waddr;
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] rptr_q;
    logic [CW-1:0] quota;
    logic [W-1:0]  mask;
    logic          in_over, in_under, out_over, out_under;

    // access decode
    always_comb begin
        rx_take  = rx_wr && !rx_oos;
        tst_take = mc_wr && test_en && !rx_take;
        wr_ok    = rx_take || tst_take;
        wdata    = rx_take ? rx_data : mc_wdata;
        do_copy  = upd_evt || (force_upd && test_en);
        waddr    = (do_copy || ptr_rst) ? '0 : wptr_q;
        quota    = CW'(quota_of(period_e'(period_sel), DEPTH));
        if (nbits == '0 || nbits >= NBW'(W)) begin
            mask = '1;
        end else begin
            mask = (W'(1) << nbits) - W'(1);
        end
    end

    // buffer storage
    always_comb begin
        st_d = st_q;
        if (do_copy) begin
            st_d.out_mem = st_q.in_mem;
        end
        if (wr_ok) begin
            st_d.in_mem[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sig_wrap_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (do_copy || ptr_rst),
        .inc   (wr_ok),
        .ptr   (wptr_q)
    );

    sig_wrap_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ptr_rst),
        .inc   (mc_rd && !ptr_rst),
        .ptr   (rptr_q)
    );

    sig_rate_mon #(.DEPTH(DEPTH)) u_in_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .access     (wr_ok),
        .period_end (do_copy),
        .quota      (quota),
        .stat_clr   (stat_rd),
        .over       (in_over),
        .under      (in_under)
    );

    sig_rate_mon #(.DEPTH(DEPTH)) u_out_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .access     (mc_rd),
        .period_end (do_copy),
        .quota      (quota),
        .stat_clr   (stat_rd),
        .over       (out_over),
        .under      (out_under)
    );

    assign mc_rdata = st_q.out_mem[rptr_q] & mask;
    assign flags    = {out_under, out_over, in_under, in_over};
endmodule

// File: rtl/sig_dbuf_chk.sv
module sig_dbuf_chk #(
    parameter int DEPTH = 48,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int NBW  = $clog2(W + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ptr_rst,
    input logic                     mc_rd,
    input logic                     mc_wr,
    input logic                     test_en,
    input logic                     rx_oos,
    input logic                     stat_rd,
    input logic                     do_copy,
    input logic [AW-1:0]            rptr,
    input logic [AW-1:0]            wptr,
    input logic [DEPTH-1:0][W-1:0]  in_mem,
    input logic [DEPTH-1:0][W-1:0]  out_mem,
    input logic [3:0]               flags,
    input logic [W-1:0]             mc_rdata,
    input logic [NBW-1:0]           nbits
);
    a_r2_copy_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        do_copy |=> out_mem == $past(in_mem));

    a_r4_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !do_copy |=> $stable(out_mem));

    a_r3_oos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_oos && !(mc_wr && test_en) && !do_copy && !ptr_rst) |=> $stable(wptr));

    a_r5_rptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_rd && !ptr_rst && rptr == AW'(DEPTH - 1)) |=> rptr == '0);

    a_r6_ptr_rst: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> rptr == '0);

    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> (($past(flags) & ~flags) == 4'b0));

    always_comb begin
        if (rst_n && nbits != '0 && nbits < NBW'(W)) begin
            a_r9_mask_high: assert ((mc_rdata >> nbits) == '0);
        end
    end
endmodule

bind sig_dbuf sig_dbuf_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_rst  (ptr_rst),
    .mc_rd    (mc_rd),
    .mc_wr    (mc_wr),
    .test_en  (test_en),
    .rx_oos   (rx_oos),
    .stat_rd  (stat_rd),
    .do_copy  (do_copy),
    .rptr     (rptr_q),
    .wptr     (wptr_q),
    .in_mem   (st_q.in_mem),
    .out_mem  (st_q.out_mem),
    .flags    (flags),
    .mc_rdata (mc_rdata),
    .nbits    (nbits)
);

// File: tb/test_sig_dbuf.sv
module test_sig_dbuf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_wr = 0, rx_oos = 0, upd_evt = 0, test_en = 0;
    logic       mc_wr = 0, force_upd = 0, ptr_rst = 0, mc_rd = 0, stat_rd = 0;
    logic [7:0] rx_data = 0, mc_wdata = 0;
    logic [1:0] period_sel = 0;
    logic [3:0] nbits = 4'd8;
    logic [7:0] mc_rdata;
    logic [3:0] flags;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    sig_dbuf i_sig_dbuf (
        .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_data(rx_data), .rx_oos(rx_oos),
        .upd_evt(upd_evt), .period_sel(period_sel), .nbits(nbits), .test_en(test_en),
        .mc_wr(mc_wr), .mc_wdata(mc_wdata), .force_upd(force_upd), .ptr_rst(ptr_rst),
        .mc_rd(mc_rd), .mc_rdata(mc_rdata), .stat_rd(stat_rd), .flags(flags)
    );

    // {nbits, data, expected masked read}
    localparam logic [19:0] VEC [8] = '{
        {4'd1, 8'hFF, 8'h01}, {4'd2, 8'hFF, 8'h03}, {4'd3, 8'h5A, 8'h02},
        {4'd4, 8'hC3, 8'h03}, {4'd7, 8'hFF, 8'h7F}, {4'd8, 8'hA5, 8'hA5},
        {4'd0, 8'h96, 8'h96}, {4'd12, 8'h3C, 8'h3C}
    };

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rx_write(input logic [7:0] d);
        rx_wr = 1; rx_data = d; cyc(); rx_wr = 0;
    endtask

    task automatic tst_write(input logic [7:0] d);
        mc_wr = 1; mc_wdata = d; cyc(); mc_wr = 0;
    endtask

    task automatic read_one(output logic [7:0] v);
        v = mc_rdata; mc_rd = 1; cyc(); mc_rd = 0;
    endtask

    task automatic upd();
        upd_evt = 1; cyc(); upd_evt = 0;
    endtask

    task automatic prst();
        ptr_rst = 1; cyc(); ptr_rst = 0;
    endtask

    task automatic sclr();
        stat_rd = 1; cyc(); stat_rd = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        chk("R1 flags", {4'b0, flags}, 8'h00);
        chk("R1 rdata", mc_rdata, 8'h00);

        // R9 mask vectors
        for (int k = 0; k < 8; k++) begin
            prst();
            rx_write(VEC[k][15:8]);
            upd();
            prst();
            nbits = VEC[k][19:16];
            cyc();
            chk($sformatf("R9 vec%0d", k), mc_rdata, VEC[k][7:0]);
        end
        nbits = 4'd8;
        sclr();
        chk("R12 cleared", {4'b0, flags}, 8'h00);

        // R3/R2/R5 full fill and in-order read
        prst();
        for (int i = 0; i < 48; i++) rx_write(8'(i * 5 + 3));
        upd();
        sclr();
        for (int i = 0; i < 48; i++) begin
            read_one(v);
            chk($sformatf("R5 rd%0d", i), v, 8'(i * 5 + 3));
        end
        chk("R5 wrap", mc_rdata, 8'd3);
        chk("R10 exact quota", {4'b0, flags}, 8'h00);
        for (int i = 0; i < 48; i++) rx_write(8'(i) ^ 8'hA5);
        chk("R4 snapshot held", mc_rdata, 8'd3);
        read_one(v);
        chk("R10 rd over", {4'b0, flags}, 8'h04);
        sclr();
        chk("R12 clear", {4'b0, flags}, 8'h00);

        // R13 read during copy
        upd_evt = 1; v = mc_rdata; mc_rd = 1; cyc(); upd_evt = 0; mc_rd = 0;
        chk("R13 old data", v, 8'd8);
        chk("R13 new next", mc_rdata, 8'd2 ^ 8'hA5);
        sclr();

        // R3 out of sync ignores writes
        prst();
        rx_oos = 1; rx_write(8'h77); rx_oos = 0;
        upd();
        chk("R3 oos ignored", mc_rdata, 8'hA5);

        // R7/R8 test hooks
        prst();
        test_en = 1; tst_write(8'h3C); test_en = 0;
        force_upd = 1; cyc(); force_upd = 0;
        chk("R8 no copy", mc_rdata, 8'hA5);
        tst_write(8'h11);
        test_en = 1; force_upd = 1; cyc(); force_upd = 0; test_en = 0;
        chk("R7 test write", mc_rdata, 8'h3C);
        read_one(v);
        chk("R7 ignored write", mc_rdata, 8'hA4);

        // R2 write in the copy cycle
        prst();
        rx_write(8'h55);
        upd_evt = 1; rx_wr = 1; rx_data = 8'h66; cyc(); upd_evt = 0; rx_wr = 0;
        prst();
        chk("R2 copy before write", mc_rdata, 8'h55);
        upd();
        chk("R2 write to entry1", mc_rdata, 8'h66);

        // R6 reset wins over read
        read_one(v);
        chk("R6 pre", mc_rdata, 8'hA4);
        ptr_rst = 1; mc_rd = 1; cyc(); ptr_rst = 0; mc_rd = 0;
        chk("R6 reset wins", mc_rdata, 8'h66);

        // R11 under with short quota
        period_sel = 2'd3;
        upd();
        sclr();
        for (int i = 0; i < 3; i++) rx_write(8'(i));
        for (int i = 0; i < 8; i++) read_one(v);
        upd();
        chk("R11 wr under", {4'b0, flags}, 8'h02);
        sclr();
        for (int i = 0; i < 8; i++) rx_write(8'(i));
        chk("R10 at quota", {4'b0, flags}, 8'h00);
        rx_write(8'h09);
        chk("R10 wr over", {4'b0, flags}, 8'h01);
        sclr();
        stat_rd = 1; rx_wr = 1; rx_data = 8'h0A; cyc(); stat_rd = 0; rx_wr = 0;
        chk("R12 set wins", {4'b0, flags}, 8'h01);
        sclr();
        chk("R12 final clear", {4'b0, flags}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule